// File: doc/BRIEF.md
# Sample Sag and Fault Detector

The block watches the instantaneous sample stream of one measurement channel, either voltage or current. It takes the absolute value of each signed sample and sums these magnitudes over a window of N valid samples, where N comes from a duration setting. At the end of each window it compares the average magnitude with a programmable level. When the average is below the level, the block raises a one-cycle event pulse and sets a sticky event flag. The flag stays set until it is cleared.

The voltage-sag and current-fault instances are identical, so one instance serves each channel. Windows follow one another without overlap. The division hidden in "average" is avoided: the block compares the window sum with the level multiplied by N, after scaling the level to the sample's fraction width. A duration of zero turns the detector off.

Samples are 24-bit two's complement fractions with 23 fraction bits. The level is unsigned with 3 integer bits and 21 fraction bits, and is used in the range 0 to 1.0. The duration is an unsigned sample count.

Top module: `sag_fault_detector`

## Requirements
- R1: After reset, `evt_flag` and `evt_pulse` are 0.
- R2: The magnitude of a sample is its absolute value. The most negative code 0x800000 saturates to 0x7FFFFF, so a window of one such sample against a level of 1.0 (0x200000) gives an event.
- R3: A window is made of `dur_cfg` consecutive samples that have `smp_vld` high. Cycles with `smp_vld` low add nothing to the window, and the next window starts with the sample after the last one.
- R4: A window gives an event when sum(|sample|) < `dur_cfg` × `lvl_cfg` × 4, which compares an average in 23-bit fraction form with the 21-bit fraction level. An average exactly equal to the level gives no event.
- R5: `evt_pulse` is high for exactly the one cycle after the clock edge that accepts the last sample of a qualifying window. It stays low for every other sample.
- R6: `evt_flag` rises together with `evt_pulse` and stays high until `evt_clr` is sampled high. If an event and a clear occur in the same cycle, the flag stays set.
- R7: When `dur_cfg` is 0, the detector is off: no sample is counted and `evt_pulse` never rises.
- R8: In any cycle where `dur_cfg` differs from its value in the previous cycle, the window restarts empty and any sample in that cycle is dropped.
- R9: The level compared at the end of a window is the value of `lvl_cfg` in the cycle of the window's last sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe |
| smp | input | 24 | Signed sample, two's complement, 23 fraction bits |
| dur_cfg | input | 24 | Window length in samples; 0 turns the detector off |
| lvl_cfg | input | 24 | Unsigned level, 3 integer and 21 fraction bits |
| evt_clr | input | 1 | Clears the sticky flag |
| evt_flag | output | 1 | Sticky event flag |
| evt_pulse | output | 1 | One-cycle event pulse |

## Verification
The assertions check the following on every cycle:
- the window counter stays below the duration while the duration is steady;
- a pulse always comes with the flag and follows an accepted sample;
- the flag holds unless cleared, and drops after a clear that meets no event;
- the pulse stays low while the duration is zero.

Only the bench scenarios can show the arithmetic, because it depends on chosen sample values. These scenarios cover the strict less-than comparison at equality, the saturation of the most negative code, the counting of valid samples across gaps, back-to-back windows, and the window restart after a duration change.

// File: rtl/sag_fault_detector.sv
module sag_fault_detector #(
  parameter int SW   = 24,
  parameter int DW   = 24,
  parameter int LW   = 24,
  parameter int LINT = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic signed [SW-1:0] smp,
  input  logic        [DW-1:0] dur_cfg,
  input  logic        [LW-1:0] lvl_cfg,
  input  logic                 evt_clr,
  output logic                 evt_flag,
  output logic                 evt_pulse
);

  localparam int MW    = SW - 1;
  localparam int LFRAC = LW - LINT;
  localparam int SHIFT = MW - LFRAC;
  localparam int AW    = MW + DW;
  localparam int TW    = LW + DW + SHIFT;
  localparam int CW    = (AW > TW) ? AW : TW;

  logic [SW-1:0] absv;
  logic [MW-1:0] mag;
  logic [AW-1:0] acc;
  logic [DW-1:0] cnt, dur_q;
  logic [CW-1:0] win_sum, thresh;
  logic          restart, off, last, hit;

  assign absv    = smp[SW-1] ? -smp : smp;
  assign mag     = absv[SW-1] ? {MW{1'b1}} : absv[MW-1:0];
  assign restart = dur_cfg != dur_q;
  assign off     = dur_cfg == '0;
  assign last    = cnt == dur_cfg - DW'(1);
  assign win_sum = CW'(acc) + CW'(mag);
  assign thresh  = (CW'(lvl_cfg) * CW'(dur_cfg)) << SHIFT;
  assign hit     = smp_vld && !off && !restart && last && (win_sum < thresh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      cnt       <= '0;
      dur_q     <= '0;
      evt_pulse <= 1'b0;
      evt_flag  <= 1'b0;
    end else begin
      dur_q     <= dur_cfg;
      evt_pulse <= hit;
      evt_flag  <= hit | (evt_flag & ~evt_clr);
      if (restart || off) begin
        acc <= '0;
        cnt <= '0;
      end else if (smp_vld) begin
        if (last) begin
          acc <= '0;
          cnt <= '0;
        end else begin
          acc <= acc + AW'(mag);
          cnt <= cnt + DW'(1);
        end
      end
    end
  end

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!off && !restart) |-> (cnt < dur_cfg)); // R3
  AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> evt_flag); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag && !evt_clr) |=> evt_flag); // R6
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr && !hit) |=> !evt_flag); // R6
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> !evt_pulse); // R7
  AST_PULSE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld || restart) |=> !evt_pulse); // R5

endmodule

// File: tb/tb_sag_fault_detector.sv
module tb_sag_fault_detector;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, smp_vld = 1'b0, evt_clr = 1'b0;
  logic signed [23:0] smp = '0;
  logic [23:0] dur_cfg = '0, lvl_cfg = '0;
  logic evt_flag, evt_pulse;
  int total = 0, bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  sag_fault_detector dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp),
    .dur_cfg(dur_cfg), .lvl_cfg(lvl_cfg), .evt_clr(evt_clr),
    .evt_flag(evt_flag), .evt_pulse(evt_pulse));

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic send(input logic [23:0] v);
    @(negedge clk);
    smp = v;
    smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk);
    evt_clr = 1'b1;
    @(negedge clk);
    evt_clr = 1'b0;
  endtask

  task automatic set_cfg(input logic [23:0] d, input logic [23:0] l);
    @(negedge clk);
    dur_cfg = d;
    lvl_cfg = l;
    idle(2);
  endtask

  task automatic t_reset();
    check("R1 flag after reset", evt_flag, 1'b0);
    check("R1 pulse after reset", evt_pulse, 1'b0);
  endtask

  task automatic t_basic_event();
    set_cfg(24'd4, 24'h100000);
    for (int i = 0; i < 3; i++) begin
      send(24'h200000);
      check("R5 no pulse mid window", evt_pulse, 1'b0);
    end
    send(24'h200000);
    check("R5 pulse at window end", evt_pulse, 1'b1);
    check("R6 flag with pulse", evt_flag, 1'b1);
    idle(1);
    check("R5 pulse one cycle", evt_pulse, 1'b0);
    check("R6 flag holds", evt_flag, 1'b1);
    clear_flag();
    check("R6 flag cleared", evt_flag, 1'b0);
  endtask

  task automatic t_no_event_signed();
    set_cfg(24'd4, 24'h100000);
    send(24'h600000); send(24'hA00000); send(24'hA00000); send(24'h600000);
    check("R2 negative samples counted by magnitude", evt_pulse, 1'b0);
    check("R2 flag stays low", evt_flag, 1'b0);
  endtask

  task automatic t_equality();
    set_cfg(24'd4, 24'h100000);
    for (int i = 0; i < 4; i++) send(24'h400000);
    check("R4 equal average no event", evt_pulse, 1'b0);
    send(24'h400000); send(24'hC00000); send(24'h400000); send(24'h3FFFFF);
    check("R4 just below level event", evt_pulse, 1'b1);
    clear_flag();
  endtask

  task automatic t_saturation();
    set_cfg(24'd1, 24'h200000);
    send(24'h800000);
    check("R2 most negative saturates", evt_pulse, 1'b1);
    clear_flag();
    set_cfg(24'd1, 24'h100000);
    send(24'h800000);
    check("R2 saturated above half level", evt_pulse, 1'b0);
  endtask

  task automatic t_gaps();
    set_cfg(24'd3, 24'h100000);
    send(24'h000010); idle(3);
    send(24'hFFFFF0); idle(2);
    check("R3 idle cycles not counted", evt_pulse, 1'b0);
    send(24'h000001);
    check("R3 third valid sample ends window", evt_pulse, 1'b1);
    clear_flag();
  endtask

  task automatic t_back_to_back();
    set_cfg(24'd2, 24'h100000);
    send(24'h000100);
    check("R5 first of pair no pulse", evt_pulse, 1'b0);
    send(24'h000100);
    check("R5 end of window 1", evt_pulse, 1'b1);
    send(24'h000100);
    check("R3 next window restarts", evt_pulse, 1'b0);
    send(24'h000100);
    check("R5 end of window 2", evt_pulse, 1'b1);
    clear_flag();
  endtask

  task automatic t_set_wins();
    set_cfg(24'd1, 24'h100000);
    @(negedge clk);
    smp = 24'h000001; smp_vld = 1'b1; evt_clr = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0; evt_clr = 1'b0;
    check("R6 event beats clear", evt_flag, 1'b1);
    clear_flag();
  endtask

  task automatic t_disabled();
    set_cfg(24'd0, 24'h200000);
    for (int i = 0; i < 5; i++) send(24'h000000);
    check("R7 zero duration no pulse", evt_pulse, 1'b0);
    check("R7 zero duration no flag", evt_flag, 1'b0);
  endtask

  task automatic t_restart();
    set_cfg(24'd4, 24'h100000);
    send(24'h000010); send(24'h000010);
    set_cfg(24'd3, 24'h100000);
    send(24'h000010);
    check("R8 restart first sample", evt_pulse, 1'b0);
    send(24'h000010);
    check("R8 restart second sample", evt_pulse, 1'b0);
    send(24'h000010);
    check("R8 restart full window", evt_pulse, 1'b1);
    clear_flag();
    @(negedge clk);
    dur_cfg = 24'd2; smp = 24'h000010; smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    send(24'h000010);
    check("R8 change-cycle sample dropped", evt_pulse, 1'b0);
    send(24'h000010);
    check("R8 window after drop", evt_pulse, 1'b1);
    clear_flag();
  endtask

  task automatic t_level_at_end();
    set_cfg(24'd2, 24'h000000);
    send(24'h000100);
    @(negedge clk);
    lvl_cfg = 24'h100000; smp = 24'h000100; smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    check("R9 level taken at last sample", evt_pulse, 1'b1);
    clear_flag();
    send(24'h000100);
    @(negedge clk);
    lvl_cfg = 24'h000000; smp = 24'h000100; smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    check("R9 zero level at end no event", evt_pulse, 1'b0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_basic_event();
    t_no_event_signed();
    t_equality();
    t_saturation();
    t_gaps();
    t_back_to_back();
    t_set_wins();
    t_disabled();
    t_restart();
    t_level_at_end();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule